// File: doc/BRIEF.md
# Tile Configuration Write Controller

This block fills the configuration memories of a row of tiles from a single incoming stream of configuration words. Every tile sees the same data bus and the same address bus. A free-running address counter sweeps every location of a tile's configuration memory. A one-hot token held in a chain of flip-flops selects which tile's write strobe is live.

Each time the address counter wraps, the token moves to the next tile. A start pulse places the token on the first tile. When the last tile's final location has been written, the token drops off the end of the chain. The block then raises a done flag and holds it until the next start.

The stream source is throttled by a ready/valid handshake. The counter and the token move only on accepted words, so a stalled source never causes a write.

Top module: `cfgload_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `cfg_we_o` is all zeros, `busy_o`, `done_o` and `bs_ready_o` are 0, and `cfg_addr_o` is 0.
- R2: A `start_i` high at a clock edge while `busy_o` is 0 makes the block busy after that edge. Tile 0 (bit 0 of `cfg_we_o`) is selected, `cfg_addr_o` is 0 and `done_o` is cleared.
- R3: `cfg_data_o` always equals `bs_data_i`. Bit t of `cfg_we_o` is high exactly when `bs_valid_i` is high, the block is busy and tile t holds the token.
- R4: At most one bit of `cfg_we_o` is high in any cycle. Exactly one is high when the block is busy and `bs_valid_i` is high.
- R5: Each accepted word (busy and `bs_valid_i` at a clock edge) raises `cfg_addr_o` by one. While `bs_valid_i` is low, the address and the selected tile hold and no write strobe is raised.
- R6: The 2^ADDR_W-th word accepted for a tile returns `cfg_addr_o` to 0. The token then moves to the next tile (bit t to bit t+1).
- R7: The word written at the last address of tile NUM_TILES-1 ends the sequence. After that edge, `busy_o` is 0, `done_o` is 1, and `cfg_we_o` stays zero whatever `bs_valid_i` does.
- R8: `done_o` stays high until a later `start_i` is taken. That start clears it and begins a fresh sequence at tile 0, address 0.
- R9: A `start_i` received while `busy_o` is 1 is ignored. The address and the selected tile continue exactly as if `start_i` were low.
- R10: `bs_ready_o` equals `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin-configuration pulse |
| bs_valid_i | input | 1 | Stream word present |
| bs_data_i | input | DATA_W | Stream word |
| bs_ready_o | output | 1 | Controller accepts stream words |
| cfg_addr_o | output | ADDR_W | Shared configuration write address |
| cfg_data_o | output | DATA_W | Shared configuration write data |
| cfg_we_o | output | NUM_TILES | Per-tile write strobe |
| busy_o | output | 1 | Configuration in progress |
| done_o | output | 1 | All tiles written |

## Verification
The bench drives a stream of gaps that repeats irregularly, so stalls land on address wraps and on the final word. A design that counted unaccepted cycles would then skip locations or write junk. Start pulses arrive in the middle of a run, which catches a controller that restarts and overwrites tile 0. After completion the bench keeps the stream valid, to catch a design that keeps strobing a tile or drops the done flag. Between runs it checks that a new start clears done, and that reset in mid-run kills every strobe.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

    // Sequence control state of the loader.
    typedef struct packed {
        logic busy;
        logic done;
    } ctrl_t;

endpackage

// File: rtl/cfgload_addr_sweep.sv
module cfgload_addr_sweep #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } sweep_t;

    sweep_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.addr = '0;
        end else if (step_i) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;
    assign wrap_o = step_i && (st_q.addr == LAST_ADDR);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(addr_o));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=> (addr_o == $past(addr_o) + 1'b1));

    // R6
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (addr_o == '0));

endmodule

// File: rtl/cfgload_token_chain.sv
module cfgload_token_chain #(
    parameter int NUM_TILES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 inject_i,
    input  logic                 shift_i,
    output logic [NUM_TILES-1:0] token_o,
    output logic                 exit_o
);
    logic [NUM_TILES-1:0] tok_d, tok_q;

    // Next value for each link of the chain.
    genvar g;
    generate
        for (g = 0; g < NUM_TILES; g++) begin : g_link
            if (g == 0) begin : g_head
                assign tok_d[g] = inject_i ? 1'b1 :
                                  shift_i  ? 1'b0 : tok_q[g];
            end else begin : g_body
                assign tok_d[g] = inject_i ? 1'b0 :
                                  shift_i  ? tok_q[g-1] : tok_q[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_q <= '0;
        end else begin
            tok_q <= tok_d;
        end
    end

    assign token_o = tok_q;
    assign exit_o  = shift_i && tok_q[NUM_TILES-1];

    // R4
    token_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_o));

    // R6
    token_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !inject_i) |=> (token_o == ($past(token_o) << 1)));

endmodule

// File: rtl/cfgload_top.sv
module cfgload_top #(
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 8,
    parameter int NUM_TILES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 bs_valid_i,
    input  logic [DATA_W-1:0]    bs_data_i,
    output logic                 bs_ready_o,
    output logic [ADDR_W-1:0]    cfg_addr_o,
    output logic [DATA_W-1:0]    cfg_data_o,
    output logic [NUM_TILES-1:0] cfg_we_o,
    output logic                 busy_o,
    output logic                 done_o
);
    import cfgload_pkg::*;

    ctrl_t ctrl_d, ctrl_q;

    logic                 start_ok;
    logic                 accept;
    logic                 tile_wrap;
    logic                 chain_exit;
    logic [NUM_TILES-1:0] token;

    assign start_ok = start_i && !ctrl_q.busy;
    assign accept   = ctrl_q.busy && bs_valid_i;

    cfgload_addr_sweep #(
        .ADDR_W (ADDR_W)
    ) i_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_ok),
        .step_i  (accept),
        .addr_o  (cfg_addr_o),
        .wrap_o  (tile_wrap)
    );

    cfgload_token_chain #(
        .NUM_TILES (NUM_TILES)
    ) i_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .inject_i (start_ok),
        .shift_i  (tile_wrap),
        .token_o  (token),
        .exit_o   (chain_exit)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (start_ok) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.done = 1'b0;
        end else if (chain_exit) begin
            ctrl_d.busy = 1'b0;
            ctrl_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cfg_data_o = bs_data_i;
    assign cfg_we_o   = accept ? token : '0;
    assign bs_ready_o = ctrl_q.busy;
    assign busy_o     = ctrl_q.busy;
    assign done_o     = ctrl_q.done;

    // R4
    we_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we_o));

    // R4
    we_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && bs_valid_i) |-> $onehot(cfg_we_o));

    // R7
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_exit && !start_i) |=> (done_o && !busy_o));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !bs_valid_i) |=> ($stable(token) && $stable(cfg_addr_o)));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

// File: tb/test_cfgload_top.sv
module test_cfgload_top;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int NUM_TILES = 4;
    localparam int DEPTH     = 1 << ADDR_W;

    // Stimulus table: {start, valid}
    localparam int NPAT = 12;
    localparam logic [1:0] PAT [NPAT] = '{
        2'b01, 2'b01, 2'b00, 2'b01, 2'b11, 2'b01,
        2'b00, 2'b00, 2'b01, 2'b11, 2'b01, 2'b01
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 bs_valid_i = 1'b0;
    logic [DATA_W-1:0]    bs_data_i = '0;
    logic                 bs_ready_o;
    logic [ADDR_W-1:0]    cfg_addr_o;
    logic [DATA_W-1:0]    cfg_data_o;
    logic [NUM_TILES-1:0] cfg_we_o;
    logic                 busy_o;
    logic                 done_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    int m_tile = 0;
    int m_addr = 0;

    always #5 clk = ~clk;

    cfgload_top #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_TILES (NUM_TILES)
    ) i_cfgload_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bs_valid_i (bs_valid_i),
        .bs_data_i  (bs_data_i),
        .bs_ready_o (bs_ready_o),
        .cfg_addr_o (cfg_addr_o),
        .cfg_data_o (cfg_data_o),
        .cfg_we_o   (cfg_we_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Check every output against the model for the current inputs.
    task automatic check_all(input bit v, input logic [DATA_W-1:0] d);
        logic [NUM_TILES-1:0] exp_we;
        exp_we = (m_busy && v) ? (NUM_TILES'(1) << m_tile) : '0;
        chk(cfg_we_o == exp_we, "R3/R4/R7 cfg_we_o", int'(cfg_we_o), int'(exp_we));
        chk(cfg_addr_o == ADDR_W'(m_addr), "R5/R6 cfg_addr_o", int'(cfg_addr_o), m_addr);
        chk(cfg_data_o == d, "R3 cfg_data_o", int'(cfg_data_o), int'(d));
        chk(busy_o == m_busy, "R2/R7 busy_o", int'(busy_o), int'(m_busy));
        chk(done_o == m_done, "R7/R8 done_o", int'(done_o), int'(m_done));
        chk(bs_ready_o == m_busy, "R10 bs_ready_o", int'(bs_ready_o), int'(m_busy));
    endtask

    task automatic step(input bit s, input bit v, input logic [DATA_W-1:0] d);
        @(negedge clk);
        start_i    = s;
        bs_valid_i = v;
        bs_data_i  = d;
        #1;
        check_all(v, d);
        // Model update at the coming edge.
        if (s && !m_busy) begin       // R2, R8; R9 when busy
            m_busy = 1'b1;
            m_done = 1'b0;
            m_tile = 0;
            m_addr = 0;
        end else if (m_busy && v) begin
            if (m_addr == DEPTH - 1) begin   // R6
                m_addr = 0;
                if (m_tile == NUM_TILES - 1) begin  // R7
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_tile = 0;
                end else begin
                    m_tile = m_tile + 1;
                end
            end else begin
                m_addr = m_addr + 1;
            end
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check_all(1'b0, '0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 8'h11);           // R1 first cycle after release

        // R2 start, then table-driven run with stalls and ignored starts (R5, R9)
        step(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 400 && m_busy; i++) begin
            step(PAT[i % NPAT][1], PAT[i % NPAT][0], 8'(i * 37 + 5));
        end
        chk(m_done, "R7 run completed", int'(m_done), 1);

        // R7/R8: done held, no strobes while valid stays high
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'(8'hA0 + i));

        // R8: restart clears done
        step(1'b1, 1'b1, 8'h5A);
        step(1'b0, 1'b1, 8'h3C);
        step(1'b0, 1'b0, 8'h3D);           // R5 stall

        // Back-to-back full run with continuous valid
        for (int i = 0; i < 100 && m_busy; i++) step(1'b0, 1'b1, 8'(i));
        step(1'b0, 1'b1, 8'hEE);

        // R1: reset in the middle of a run
        step(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 8'(i + 3));
        @(negedge clk);
        rst_n = 1'b0;
        m_busy = 1'b0; m_done = 1'b0; m_tile = 0; m_addr = 0;
        step(1'b0, 1'b1, 8'h77);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 8'h78);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule